// File: doc/BRIEF.md
# Processor Presence Bitmap with Hot-Add Event

This block keeps one presence bit per processor ID and lets firmware read the bits one byte at a time. At reset it loads the set of processors that exist at boot from a wide input vector. After reset, a hot-add strobe with a processor ID sets that processor's bit. Bits are only ever set, never cleared.

Each accepted hot-add also sets a fixed bit in a general-purpose-event status byte. The interrupt output follows that status byte masked by an enable byte that comes from outside the block. Software acknowledges the event with a write-one-to-clear mask. The block has a byte-wide write port. Writes to it are accepted on the bus and then discarded.

Top module: `cpu_presence_map`

## Requirements
- R1: While `rst_n` is low, byte j of the bitmap loads from `boot_present[8j+7:8j]`. During reset `gpe_sts`, `rd_data` and `hp_err` are 0.
- R2: Processor ID n is stored in bit (n mod 8) of byte (n div 8). A read with `rd_en` high places byte `rd_addr` on `rd_data` after the next rising edge. While `rd_en` is low, `rd_data` keeps its value.
- R3: A hot-add (`hp_valid` high) with an ID below MAX_CPUS (256) sets that ID's bit. It leaves every other bit unchanged, and no operation ever clears a bit.
- R4: An accepted hot-add sets bit 2 of `gpe_sts` (value 0x04) at the same edge. No other `gpe_sts` bit is ever set.
- R5: `sci` is high exactly when some bit is set in both `gpe_sts` and `gpe_enable`. It follows combinationally from the registered status.
- R6: A 1 in bit k of `gpe_clr` clears status bit k at the next edge. If a clear and an accepted hot-add arrive in the same cycle, bit 2 ends up set.
- R7: Writes through `wr_en`/`wr_addr`/`wr_data` change no bitmap byte and no status bit.
- R8: If a read and a hot-add to the same byte happen in the same cycle, the read returns the byte as it was before the update. The next read of that byte shows the new bit.
- R9: A hot-add whose ID is MAX_CPUS or above changes neither the bitmap nor `gpe_sts`. It raises `hp_err` for exactly the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, loads the boot bitmap |
| boot_present | input | 256 | Presence of each processor at boot, bit n = ID n |
| rd_en | input | 1 | Byte read strobe |
| rd_addr | input | 5 | Byte index within the window |
| rd_data | output | 8 | Registered read data |
| wr_en | input | 1 | Write strobe (discarded) |
| wr_addr | input | 5 | Write byte index (discarded) |
| wr_data | input | 8 | Write data (discarded) |
| hp_valid | input | 1 | Hot-add event strobe |
| hp_id | input | 9 | Processor ID of the hot-add |
| gpe_enable | input | 8 | Event enable mask |
| gpe_clr | input | 8 | Write-one-to-clear mask for status |
| gpe_sts | output | 8 | Event status byte |
| sci | output | 1 | Interrupt line |
| hp_err | output | 1 | One-cycle pulse for an out-of-range hot-add ID |

## Verification
A wrong bit index or byte decode does not appear at once. It shows up only when the affected byte is read, one edge after the read strobe. For that reason every hot-add in the bench is followed by a read of exactly the byte it should have touched. A lost or stuck status bit shows on `gpe_sts` and `sci` in the cycle right after the event or clear edge. The case where an update and a read collide is the only place the ordering of the read register against the store can be seen. It is tested directly.

// File: rtl/cpu_hp_pkg.sv
package cpu_hp_pkg;
   localparam int BYTE_W = 8;

   function automatic logic [BYTE_W-1:0] bit_select(input logic [2:0] pos);
      return BYTE_W'(1) << pos;
   endfunction
endpackage

// File: rtl/cpu_id_decode.sv
module cpu_id_decode #(
   parameter int ID_W     = 9,
   parameter int MAX_CPUS = 256,
   localparam int NUM_BYTES = MAX_CPUS / cpu_hp_pkg::BYTE_W,
   localparam int ADDR_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
   input  logic [ID_W-1:0]   id,
   output logic [ADDR_W-1:0] byte_idx,
   output logic [7:0]        bit_mask,
   output logic              in_range
);
   localparam logic [ID_W:0] LIMIT = (ID_W+1)'(MAX_CPUS);

   if (ID_W < ADDR_W + 3) begin : g_bad_idw
      $error("ID_W too narrow for MAX_CPUS");
   end

   always_comb begin
      in_range = ({1'b0, id} < LIMIT);
      byte_idx = id[ADDR_W+2:3];
      bit_mask = cpu_hp_pkg::bit_select(id[2:0]);
   end
endmodule

// File: rtl/cpu_bitmap_store.sv
module cpu_bitmap_store #(
   parameter int NUM_BYTES = 32,
   localparam int ADDR_W   = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
   localparam int VEC_W    = NUM_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VEC_W-1:0]  boot_vec,
   input  logic              set_en,
   input  logic [ADDR_W-1:0] set_idx,
   input  logic [7:0]        set_mask,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data
);
   logic [7:0] map_q [NUM_BYTES];
   logic [7:0] rd_sel;
   logic [7:0] rd_q;

   always_ff @(posedge clk) begin
      for (int b = 0; b < NUM_BYTES; b++) begin
         if (!rst_n)
            map_q[b] <= boot_vec[b*8 +: 8];
         else if (set_en && (set_idx == ADDR_W'(b)))
            map_q[b] <= map_q[b] | set_mask;
      end
   end

   if (NUM_BYTES == (1 << ADDR_W)) begin : g_full_window
      assign rd_sel = map_q[rd_addr];
   end else begin : g_partial_window
      always_comb begin
         rd_sel = '0;
         for (int b = 0; b < NUM_BYTES; b++)
            if (rd_addr == ADDR_W'(b)) rd_sel = map_q[b];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= rd_sel;
   end

   assign rd_data = rd_q;
endmodule

// File: rtl/gpe_event.sv
module gpe_event #(
   parameter int STS_W  = 8,
   parameter int HP_BIT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_evt,
   input  logic [STS_W-1:0] clr_mask,
   input  logic [STS_W-1:0] enable,
   output logic [STS_W-1:0] sts,
   output logic             sci
);
   localparam logic [STS_W-1:0] HP_MASK = STS_W'(1) << HP_BIT;

   if (HP_BIT >= STS_W) begin : g_bad_bit
      $error("HP_BIT outside status byte");
   end

   logic [STS_W-1:0] sts_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= (sts_q & ~clr_mask) | (set_evt ? HP_MASK : '0);
   end

   assign sts = sts_q;
   assign sci = |(sts_q & enable);
endmodule

// File: rtl/cpu_presence_map.sv
module cpu_presence_map #(
   parameter int MAX_CPUS   = 256,
   parameter int ID_W       = 9,
   parameter int GPE_W      = 8,
   parameter int HP_STS_BIT = 2,
   localparam int NUM_BYTES = MAX_CPUS / 8,
   localparam int ADDR_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [MAX_CPUS-1:0] boot_present,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [7:0]          rd_data,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [7:0]          wr_data,
   input  logic                hp_valid,
   input  logic [ID_W-1:0]     hp_id,
   input  logic [GPE_W-1:0]    gpe_enable,
   input  logic [GPE_W-1:0]    gpe_clr,
   output logic [GPE_W-1:0]    gpe_sts,
   output logic                sci,
   output logic                hp_err
);
   if (MAX_CPUS % 8 != 0 || MAX_CPUS < 8) begin : g_bad_max
      $error("MAX_CPUS must be a positive multiple of 8");
   end

   logic [ADDR_W-1:0] dec_idx;
   logic [7:0]        dec_mask;
   logic              dec_ok;
   logic              accept;
   logic              err_q;
   logic              wr_unused_sink;

   assign wr_unused_sink = ^{wr_en, wr_addr, wr_data};

   cpu_id_decode #(.ID_W(ID_W), .MAX_CPUS(MAX_CPUS)) u_dec (
      .id(hp_id), .byte_idx(dec_idx), .bit_mask(dec_mask), .in_range(dec_ok)
   );

   assign accept = hp_valid & dec_ok;

   cpu_bitmap_store #(.NUM_BYTES(NUM_BYTES)) u_store (
      .clk(clk), .rst_n(rst_n), .boot_vec(boot_present),
      .set_en(accept), .set_idx(dec_idx), .set_mask(dec_mask),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   gpe_event #(.STS_W(GPE_W), .HP_BIT(HP_STS_BIT)) u_gpe (
      .clk(clk), .rst_n(rst_n), .set_evt(accept), .clr_mask(gpe_clr),
      .enable(gpe_enable), .sts(gpe_sts), .sci(sci)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= hp_valid & ~dec_ok;
   end

   assign hp_err = err_q;
endmodule

// File: rtl/cpu_presence_map_chk.sv
module cpu_presence_map_chk #(
   parameter int MAX_CPUS   = 256,
   parameter int ID_W       = 9,
   parameter int GPE_W      = 8,
   parameter int HP_STS_BIT = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_en,
   input logic [7:0]       rd_data,
   input logic             hp_valid,
   input logic [ID_W-1:0]  hp_id,
   input logic [GPE_W-1:0] gpe_enable,
   input logic [GPE_W-1:0] gpe_clr,
   input logic [GPE_W-1:0] gpe_sts,
   input logic             sci,
   input logic             hp_err
);
   localparam logic [ID_W:0] LIMIT = (ID_W+1)'(MAX_CPUS);
   logic good_add, bad_add;
   assign good_add = hp_valid && ({1'b0, hp_id} < LIMIT);
   assign bad_add  = hp_valid && !({1'b0, hp_id} < LIMIT);

   // R2
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
   // R4
   hp_sets_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      good_add |=> gpe_sts[HP_STS_BIT]);
   // R4
   other_sts_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gpe_sts) <= 1 && (gpe_sts == '0 || gpe_sts[HP_STS_BIT]));
   // R5
   sci_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gpe_sts[HP_STS_BIT] && gpe_enable[HP_STS_BIT]) |-> sci);
   // R5
   sci_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gpe_sts == '0) |-> !sci);
   // R6
   clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gpe_clr[HP_STS_BIT] && !good_add) |=> !gpe_sts[HP_STS_BIT]);
   // R9
   bad_id_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_add |=> hp_err);
   // R9
   err_only_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bad_add |=> !hp_err);
   // R9
   bad_id_no_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_add && !gpe_sts[HP_STS_BIT]) |=> !gpe_sts[HP_STS_BIT]);
endmodule

bind cpu_presence_map cpu_presence_map_chk #(
   .MAX_CPUS(MAX_CPUS), .ID_W(ID_W), .GPE_W(GPE_W), .HP_STS_BIT(HP_STS_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data),
   .hp_valid(hp_valid), .hp_id(hp_id), .gpe_enable(gpe_enable),
   .gpe_clr(gpe_clr), .gpe_sts(gpe_sts), .sci(sci), .hp_err(hp_err)
);

// File: tb/test_cpu_presence_map.sv
module test_cpu_presence_map;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 32;

   logic         clk = 0;
   logic         rst_n = 0;
   logic [255:0] boot_present;
   logic         rd_en = 0;
   logic [4:0]   rd_addr = 0;
   logic [7:0]   rd_data;
   logic         wr_en = 0;
   logic [4:0]   wr_addr = 0;
   logic [7:0]   wr_data = 0;
   logic         hp_valid = 0;
   logic [8:0]   hp_id = 0;
   logic [7:0]   gpe_enable = 0;
   logic [7:0]   gpe_clr = 0;
   logic [7:0]   gpe_sts;
   logic         sci;
   logic         hp_err;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   logic [7:0] model [NB];

   localparam logic [8:0] HP_TABLE [0:9] =
      '{9'd0, 9'd7, 9'd8, 9'd255, 9'd100, 9'd37, 9'd200, 9'd128, 9'd1, 9'd63};

   always #(CLK_PERIOD/2) clk = ~clk;

   cpu_presence_map i_cpu_presence_map (
      .clk(clk), .rst_n(rst_n), .boot_present(boot_present),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .hp_valid(hp_valid), .hp_id(hp_id), .gpe_enable(gpe_enable),
      .gpe_clr(gpe_clr), .gpe_sts(gpe_sts), .sci(sci), .hp_err(hp_err)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   task automatic read_byte(input logic [4:0] a, output logic [7:0] d);
      rd_en = 1; rd_addr = a;
      @(negedge clk);
      rd_en = 0;
      d = rd_data;
   endtask

   task automatic hot_add(input logic [8:0] id);
      hp_valid = 1; hp_id = id;
      @(negedge clk);
      hp_valid = 0;
      if (id < 256) model[id[7:3]] = model[id[7:3]] | (8'd1 << id[2:0]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
   end

   initial begin
      logic [7:0] d;
      for (int j = 0; j < NB; j++) begin
         model[j] = 8'(j*29 + 3);
         boot_present[j*8 +: 8] = 8'(j*29 + 3);
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 sts", gpe_sts, 8'h00);
      chk("R1 rd_data", rd_data, 8'h00);
      chk("R1 hp_err", {7'd0, hp_err}, 8'h00);
      rst_n = 1;
      @(negedge clk);
      // R1 R2 boot bitmap readback
      for (int j = 0; j < NB; j++) begin
         read_byte(5'(j), d);
         chk("R1 boot byte", d, model[j]);
      end
      // R2 hold while idle
      @(negedge clk);
      chk("R2 hold", rd_data, model[NB-1]);
      // R3 R4 vector table
      for (int i = 0; i < 10; i++) begin
         hot_add(HP_TABLE[i]);
         chk("R4 sts after add", gpe_sts, 8'h04);
         read_byte(HP_TABLE[i][7:3], d);
         chk("R3 byte after add", d, model[HP_TABLE[i][7:3]]);
      end
      // R3 neighbours untouched
      read_byte(5'd2, d);
      chk("R3 untouched byte", d, model[2]);
      // R5 interrupt masking
      chk("R5 sci masked", {7'd0, sci}, 8'h00);
      gpe_enable = 8'h04; @(negedge clk);
      chk("R5 sci enabled", {7'd0, sci}, 8'h01);
      gpe_enable = 8'hFB; @(negedge clk);
      chk("R5 sci other enables", {7'd0, sci}, 8'h00);
      gpe_enable = 8'h04;
      // R6 clear
      gpe_clr = 8'h04; @(negedge clk); gpe_clr = 0;
      chk("R6 cleared", gpe_sts, 8'h00);
      chk("R6 sci low", {7'd0, sci}, 8'h00);
      // R6 set wins over clear
      gpe_clr = 8'h04; hot_add(9'd2); gpe_clr = 0;
      chk("R6 set wins", gpe_sts, 8'h04);
      gpe_clr = 8'h04; @(negedge clk); gpe_clr = 0;
      // R7 writes ignored
      wr_en = 1; wr_addr = 5'd3; wr_data = 8'h00; @(negedge clk);
      wr_data = 8'hFF; @(negedge clk); wr_en = 0;
      read_byte(5'd3, d);
      chk("R7 write ignored", d, model[3]);
      chk("R7 sts unchanged", gpe_sts, 8'h00);
      // R8 same-cycle add and read
      rd_en = 1; rd_addr = 5'd5;
      hot_add(9'd46);
      rd_en = 0;
      chk("R8 old byte", rd_data, 8'(5*29 + 3));
      read_byte(5'd5, d);
      chk("R8 new byte", d, model[5]);
      gpe_clr = 8'h04; @(negedge clk); gpe_clr = 0;
      // R9 out-of-range ID
      hot_add(9'd300);
      chk("R9 err pulse", {7'd0, hp_err}, 8'h01);
      chk("R9 no sts", gpe_sts, 8'h00);
      @(negedge clk);
      chk("R9 err clears", {7'd0, hp_err}, 8'h00);
      read_byte(5'd5, d);
      chk("R9 bitmap unchanged", d, model[5]);
      report();
   end
endmodule